// File: doc/BRIEF.md
# Dual-Channel DAC Register Interface

This block is the digital control core of a two-channel digital-to-analog converter driven from a parallel bus. Each channel holds a data code and a 3-bit output-range (span) code. Both are double-buffered: a staging register is loaded by a write command, and an update command moves the staged value into the live register that sets the converter output. A two-bit address steers each command to channel A, to channel B, to both channels or to neither.

A data/span select input picks which register set a write or a readback touches. An update always moves both sets. Readback drives the selected staging register onto a tri-state bus while the read input is high. An asynchronous active-low clear forces the data registers to the code that gives zero volts in the range that is live at that moment. A fixed-range mode input ties both span registers of each channel to a strapped 3-bit value. In that mode span writes and span updates have no effect.

Top module: `dual_dac_regif`

## Requirements
- R1: With wr high, rd low and span_sel low, data_in is loaded into the staging data register of the addressed channel(s) on the next clock edge. Address encoding: 00 = channel A, 01 = channel B, 11 = both, 10 = none. The live data is unchanged.
- R2: With wr high, rd low, span_sel high and fixed_span low, span_in is loaded into the staging span register of the addressed channel(s), using the R1 address encoding.
- R3: An update (upd high) copies the staging data and staging span registers into the live registers of the addressed channel(s). span_sel has no effect on an update.
- R4: With rd high, the staging register selected by span_sel (low = data on data_q, high = span on span_q) is driven with its enable (data_oe or span_oe) high. Address 00 or 11 reads channel A, 01 reads channel B, and 10 drives nothing.
- R5: With rd low, data_oe and span_oe are low and both readback buses are high-impedance.
- R6: A write issued while rd is high changes no register.
- R7: Taking clr_n low at once sets the staging and live data registers of both channels to the zero-volt code of that channel's live span. Spans 2 to 5 are bipolar and give a code with only the MSB set. Spans 0, 1, 6 and 7 give all zeros.
- R8: While fixed_span is high, the staging and live spans of both channels equal strap_span, and span writes and span updates do not change the stored spans.
- R9: A synchronous reset sets every stored span to 0 and every data register to the zero-volt code of its effective span.
- R10: A write and an update in the same cycle move the staging contents from before that edge into the live register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_n | input | 1 | Asynchronous active-low data clear |
| addr | input | 2 | Channel address |
| wr | input | 1 | Write command |
| upd | input | 1 | Update command |
| rd | input | 1 | Readback enable |
| span_sel | input | 1 | 0 selects data registers, 1 selects span registers |
| fixed_span | input | 1 | Fixed-range mode |
| strap_span | input | 3 | Strapped span used in fixed-range mode |
| data_in | input | DATA_W | Write data code |
| span_in | input | 3 | Write span code |
| data_q | output | DATA_W | Tri-state data readback |
| data_oe | output | 1 | data_q is driven |
| span_q | output | 3 | Tri-state span readback |
| span_oe | output | 1 | span_q is driven |
| live_data_a | output | DATA_W | Live data code, channel A |
| live_data_b | output | DATA_W | Live data code, channel B |
| live_span_a | output | 3 | Live span, channel A |
| live_span_b | output | 3 | Live span, channel B |

## Verification
The hardest case to reach is a clear that lands when the two channels hold different live spans, one bipolar and one unipolar. Under that condition each channel must pick its own zero-volt code. The stimulus first writes and updates a different span into each channel, then updates nonzero data, and only then pulses clr_n between clock edges. A later pass repeats the clear in fixed-range mode, where the strapped span, not the stored one, picks the code. Span 7 is also placed in a channel before a clear to exercise the unused codes.

// File: rtl/dual_dac_regif_pkg.sv
package dual_dac_regif_pkg;

    typedef logic [2:0] span_t;

    typedef struct packed {
        logic ch_b;
        logic ch_a;
    } chan_mask_t;

    // write/update targets: 00 A, 01 B, 11 both, 10 none
    function automatic chan_mask_t target_mask(input logic [1:0] addr);
        chan_mask_t m;
        m.ch_a = (addr == 2'b00) || (addr == 2'b11);
        m.ch_b = (addr == 2'b01) || (addr == 2'b11);
        return m;
    endfunction

    function automatic logic span_is_bipolar(input span_t s);
        return (s >= 3'd2) && (s <= 3'd5);
    endfunction

endpackage

// File: rtl/dual_dac_regif_chan.sv
module dual_dac_regif_chan
    import dual_dac_regif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic              fixed_span,
    input  span_t             strap_span,
    input  logic              wr_data,
    input  logic              wr_span,
    input  logic              upd,
    input  logic [DATA_W-1:0] data_in,
    input  span_t             span_in,
    output logic [DATA_W-1:0] stage_data,
    output logic [DATA_W-1:0] live_data,
    output span_t             stage_span,
    output span_t             live_span
);

    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    span_t             sp_stage_r, sp_live_r;
    logic [DATA_W-1:0] d_stage_r, d_live_r;
    logic [DATA_W-1:0] clr_code, rst_code;

    assign stage_span = fixed_span ? strap_span : sp_stage_r;
    assign live_span  = fixed_span ? strap_span : sp_live_r;
    assign clr_code   = span_is_bipolar(live_span) ? MID_CODE : '0;
    assign rst_code   = (fixed_span && span_is_bipolar(strap_span)) ? MID_CODE : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            sp_stage_r <= '0;
            sp_live_r  <= '0;
        end else begin
            if (wr_span && !fixed_span)
                sp_stage_r <= span_in;
            if (upd && !fixed_span)
                sp_live_r <= sp_stage_r;
        end
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            d_stage_r <= clr_code;
            d_live_r  <= clr_code;
        end else if (rst) begin
            d_stage_r <= rst_code;
            d_live_r  <= rst_code;
        end else begin
            if (wr_data)
                d_stage_r <= data_in;
            if (upd)
                d_live_r <= d_stage_r;
        end
    end

    assign stage_data = d_stage_r;
    assign live_data  = d_live_r;

endmodule

// File: rtl/dual_dac_regif_rdmux.sv
module dual_dac_regif_rdmux
    import dual_dac_regif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              rd,
    input  logic              span_sel,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] data_a,
    input  logic [DATA_W-1:0] data_b,
    input  span_t             span_a,
    input  span_t             span_b,
    output logic [DATA_W-1:0] data_q,
    output logic              data_oe,
    output span_t             span_q,
    output logic              span_oe
);

    logic pick_b, addr_ok;

    assign pick_b  = (addr == 2'b01);
    assign addr_ok = (addr != 2'b10);
    assign data_oe = rd && !span_sel && addr_ok;
    assign span_oe = rd && span_sel && addr_ok;
    assign data_q  = data_oe ? (pick_b ? data_b : data_a) : 'z;
    assign span_q  = span_oe ? (pick_b ? span_b : span_a) : 'z;

endmodule

// File: rtl/dual_dac_regif.sv
module dual_dac_regif
    import dual_dac_regif_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_n,
    input  logic [1:0]        addr,
    input  logic              wr,
    input  logic              upd,
    input  logic              rd,
    input  logic              span_sel,
    input  logic              fixed_span,
    input  logic [2:0]        strap_span,
    input  logic [DATA_W-1:0] data_in,
    input  logic [2:0]        span_in,
    output logic [DATA_W-1:0] data_q,
    output logic              data_oe,
    output logic [2:0]        span_q,
    output logic              span_oe,
    output logic [DATA_W-1:0] live_data_a,
    output logic [DATA_W-1:0] live_data_b,
    output logic [2:0]        live_span_a,
    output logic [2:0]        live_span_b
);

    localparam int NCH = 2;

    chan_mask_t        tgt;
    logic [NCH-1:0]    en;
    logic              wr_ok;
    logic [DATA_W-1:0] stage_data [NCH];
    logic [DATA_W-1:0] live_data  [NCH];
    span_t             stage_span [NCH];
    span_t             live_span  [NCH];

    assign tgt   = target_mask(addr);
    assign en    = {tgt.ch_b, tgt.ch_a};
    assign wr_ok = wr && !rd;   // R6

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        dual_dac_regif_chan #(.DATA_W(DATA_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .clr_n      (clr_n),
            .fixed_span (fixed_span),
            .strap_span (strap_span),
            .wr_data    (wr_ok && !span_sel && en[g]),
            .wr_span    (wr_ok && span_sel && en[g]),
            .upd        (upd && en[g]),
            .data_in    (data_in),
            .span_in    (span_in),
            .stage_data (stage_data[g]),
            .live_data  (live_data[g]),
            .stage_span (stage_span[g]),
            .live_span  (live_span[g])
        );
    end

    dual_dac_regif_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .rd       (rd),
        .span_sel (span_sel),
        .addr     (addr),
        .data_a   (stage_data[0]),
        .data_b   (stage_data[1]),
        .span_a   (stage_span[0]),
        .span_b   (stage_span[1]),
        .data_q   (data_q),
        .data_oe  (data_oe),
        .span_q   (span_q),
        .span_oe  (span_oe)
    );

    assign live_data_a = live_data[0];
    assign live_data_b = live_data[1];
    assign live_span_a = live_span[0];
    assign live_span_b = live_span[1];

endmodule

// File: rtl/dual_dac_regif_chk.sv
module dual_dac_regif_chk #(
    parameter int DATA_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              clr_n,
    input logic [1:0]        addr,
    input logic              upd,
    input logic              rd,
    input logic              fixed_span,
    input logic [2:0]        strap_span,
    input logic              data_oe,
    input logic              span_oe,
    input logic [DATA_W-1:0] stage_data_a,
    input logic [DATA_W-1:0] live_data_a,
    input logic [2:0]        stage_span_a,
    input logic [2:0]        live_span_a
);

    logic hits_a;
    assign hits_a = (addr == 2'b00) || (addr == 2'b11);

    a_r5_bus_released: assert property (@(posedge clk) disable iff (rst)
        !rd |-> (!data_oe && !span_oe));

    a_r4_one_bus: assert property (@(posedge clk) disable iff (rst)
        $onehot0({data_oe, span_oe}));

    a_r8_strap_follow: assert property (@(posedge clk) disable iff (rst)
        fixed_span |-> (live_span_a == strap_span && stage_span_a == strap_span));

    a_r3_upd_data: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (upd && hits_a) |=> (live_data_a == $past(stage_data_a)));

    a_r3_upd_span: assert property (@(posedge clk) disable iff (rst)
        (upd && hits_a && !fixed_span) |=> (fixed_span || live_span_a == $past(stage_span_a)));

    a_r6_read_blocks_write: assert property (@(posedge clk) disable iff (rst || !clr_n)
        rd |=> (stage_data_a == $past(stage_data_a)));

endmodule

bind dual_dac_regif dual_dac_regif_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .clr_n        (clr_n),
    .addr         (addr),
    .upd          (upd),
    .rd           (rd),
    .fixed_span   (fixed_span),
    .strap_span   (strap_span),
    .data_oe      (data_oe),
    .span_oe      (span_oe),
    .stage_data_a (stage_data[0]),
    .live_data_a  (live_data[0]),
    .stage_span_a (stage_span[0]),
    .live_span_a  (live_span[0])
);

// File: tb/dual_dac_regif_test.sv
`timescale 1ns/100ps
module dual_dac_regif_test;

    localparam int W = 12;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr_n = 1'b1;
    logic [1:0]   addr = 2'b10;
    logic         wr = 1'b0, upd = 1'b0, rd = 1'b0, span_sel = 1'b0;
    logic         fixed_span = 1'b0;
    logic [2:0]   strap_span = 3'd0;
    logic [W-1:0] data_in = '0;
    logic [2:0]   span_in = 3'd0;
    wire  [W-1:0] data_q;
    wire          data_oe;
    wire  [2:0]   span_q;
    wire          span_oe;
    wire  [W-1:0] live_data_a, live_data_b;
    wire  [2:0]   live_span_a, live_span_b;

    int checks = 0;
    int fails  = 0;
    string phase = "R9";

    // behavioural reference state
    int m_sd[2], m_ld[2], m_ss[2], m_ls[2];

    dual_dac_regif #(.DATA_W(W)) uut (
        .clk(clk), .rst(rst), .clr_n(clr_n), .addr(addr), .wr(wr), .upd(upd),
        .rd(rd), .span_sel(span_sel), .fixed_span(fixed_span),
        .strap_span(strap_span), .data_in(data_in), .span_in(span_in),
        .data_q(data_q), .data_oe(data_oe), .span_q(span_q), .span_oe(span_oe),
        .live_data_a(live_data_a), .live_data_b(live_data_b),
        .live_span_a(live_span_a), .live_span_b(live_span_b)
    );

    always #2.5 clk = ~clk;

    function automatic int zc(input int s);
        return (s >= 2 && s <= 5) ? (1 << (W - 1)) : 0;
    endfunction

    function automatic int eff(input int s);
        return fixed_span ? int'(strap_span) : s;
    endfunction

    function automatic bit targets(input int ch);
        if (ch == 0) return (addr == 2'b00) || (addr == 2'b11);
        return (addr == 2'b01) || (addr == 2'b11);
    endfunction

    always @(posedge clk) begin
        int osd[2], old[2], oss[2], ols[2];
        osd = m_sd; old = m_ld; oss = m_ss; ols = m_ls;
        for (int ch = 0; ch < 2; ch++) begin
            if (rst) begin
                m_ss[ch] = 0;
                m_ls[ch] = 0;
            end else begin
                if (wr && !rd && span_sel && targets(ch) && !fixed_span) m_ss[ch] = span_in;
                if (upd && targets(ch) && !fixed_span) m_ls[ch] = oss[ch];
            end
            if (!clr_n) begin
                m_sd[ch] = zc(eff(ols[ch]));
                m_ld[ch] = zc(eff(ols[ch]));
            end else if (rst) begin
                m_sd[ch] = zc(eff(0));
                m_ld[ch] = zc(eff(0));
            end else begin
                if (wr && !rd && !span_sel && targets(ch)) m_sd[ch] = data_in;
                if (upd && targets(ch)) m_ld[ch] = osd[ch];
            end
        end
    end

    always @(negedge clr_n) begin
        for (int ch = 0; ch < 2; ch++) begin
            m_sd[ch] = zc(eff(m_ls[ch]));
            m_ld[ch] = zc(eff(m_ls[ch]));
        end
    end

    task automatic chk(input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0h expected %0h", phase, what, got, exp);
        end
    endtask

    task automatic compare_all();
        int rch;
        bit ok_addr;
        rch = (addr == 2'b01) ? 1 : 0;
        ok_addr = (addr != 2'b10);
        chk("live_data_a", live_data_a, m_ld[0]);
        chk("live_data_b", live_data_b, m_ld[1]);
        chk("live_span_a", live_span_a, eff(m_ls[0]));
        chk("live_span_b", live_span_b, eff(m_ls[1]));
        chk("data_oe", data_oe, rd && !span_sel && ok_addr);
        chk("span_oe", span_oe, rd && span_sel && ok_addr);
        if (data_oe) chk("data_q", data_q, m_sd[rch]);
        if (span_oe) chk("span_q", span_q, eff(m_ss[rch]));
    endtask

    // compare every cycle, 1 ns after the falling edge
    always @(negedge clk) begin
        #1;
        if (!rst) compare_all();
    end

    task automatic cyc(input logic [1:0] a, input logic w, input logic u,
                       input logic r, input logic s,
                       input logic [W-1:0] d, input logic [2:0] sp);
        @(negedge clk);
        addr = a; wr = w; upd = u; rd = r; span_sel = s; data_in = d; span_in = sp;
    endtask

    task automatic idle();
        cyc(2'b10, 0, 0, 0, 0, '0, 3'd0);
    endtask

    task automatic pulse_clear();
        idle();
        @(negedge clk);
        #0.5 clr_n = 1'b0;
        #1;
        chk("clr live_data_a", live_data_a, m_ld[0]);
        chk("clr live_data_b", live_data_b, m_ld[1]);
        @(negedge clk);
        @(negedge clk);
        #0.5 clr_n = 1'b1;
        idle();
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog expired in %s", phase);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        m_sd = '{0, 0}; m_ld = '{0, 0}; m_ss = '{0, 0}; m_ls = '{0, 0};
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        #1;
        chk("R9 reset live_data_a", live_data_a, 0);
        chk("R9 reset live_span_b", live_span_b, 0);
        idle();

        phase = "R1";
        cyc(2'b00, 1, 0, 0, 0, 12'h123, 0);
        cyc(2'b01, 1, 0, 0, 0, 12'h456, 0);
        cyc(2'b10, 1, 0, 0, 0, 12'hFFF, 0);
        idle();
        #1 chk("R1 live A unchanged", live_data_a, 0);
        cyc(2'b11, 1, 0, 0, 0, 12'hABC, 0);
        idle();

        phase = "R2";
        cyc(2'b00, 1, 0, 0, 1, 0, 3'd3);
        cyc(2'b01, 1, 0, 0, 1, 0, 3'd1);
        cyc(2'b10, 1, 0, 0, 1, 0, 3'd5);
        idle();

        phase = "R4";
        cyc(2'b00, 0, 0, 1, 1, 0, 0);
        cyc(2'b01, 0, 0, 1, 1, 0, 0);
        cyc(2'b11, 0, 0, 1, 0, 0, 0);
        cyc(2'b01, 0, 0, 1, 0, 0, 0);
        cyc(2'b10, 0, 0, 1, 0, 0, 0);
        #1 chk("R4 no channel drives", data_oe, 0);

        phase = "R3";
        cyc(2'b00, 0, 1, 0, 1, 0, 0);
        idle();
        #1 chk("R3 span A live", live_span_a, 3);
        chk("R3 data A live", live_data_a, 12'hABC);
        cyc(2'b01, 0, 1, 0, 0, 0, 0);
        cyc(2'b10, 0, 1, 0, 0, 0, 0);
        idle();

        phase = "R5";
        cyc(2'b00, 0, 0, 0, 0, 0, 0);
        #1 chk("R5 idle bus", data_oe | span_oe, 0);

        phase = "R6";
        cyc(2'b11, 1, 0, 1, 0, 12'h777, 0);
        cyc(2'b11, 1, 0, 1, 1, 0, 3'd6);
        cyc(2'b00, 0, 0, 1, 0, 0, 0);
        #1 chk("R6 readback after blocked write", data_q, 12'hABC);

        phase = "R10";
        cyc(2'b00, 1, 1, 0, 0, 12'h321, 0);
        idle();
        #1 chk("R10 live A holds old stage", live_data_a, 12'hABC);
        cyc(2'b00, 0, 1, 0, 0, 0, 0);
        idle();
        #1 chk("R10 live A takes new stage", live_data_a, 12'h321);

        phase = "R7";
        pulse_clear();
        #1 chk("R7 bipolar A midscale", live_data_a, 12'h800);
        chk("R7 unipolar B zero", live_data_b, 0);
        cyc(2'b01, 1, 0, 0, 1, 0, 3'd7);
        cyc(2'b11, 1, 0, 0, 0, 12'h5A5, 0);
        cyc(2'b11, 0, 1, 0, 0, 0, 0);
        pulse_clear();
        #1 chk("R7 span 7 clears to zero", live_data_b, 0);

        phase = "R8";
        @(negedge clk);
        fixed_span = 1'b1; strap_span = 3'd4;
        cyc(2'b11, 1, 0, 0, 1, 0, 3'd1);
        cyc(2'b11, 0, 1, 0, 0, 0, 0);
        cyc(2'b01, 0, 0, 1, 1, 0, 0);
        #1 chk("R8 span readback strapped", span_q, 4);
        cyc(2'b11, 1, 0, 0, 0, 12'h0F0, 0);
        cyc(2'b11, 0, 1, 0, 0, 0, 0);
        pulse_clear();
        #1 chk("R8 clear uses strap span", live_data_b, 12'h800);
        @(negedge clk);
        fixed_span = 1'b0;
        idle();
        #1 chk("R8 stored span kept", live_span_b, 7);

        phase = "R3";
        for (int i = 0; i < 400; i++) begin
            cyc(2'($urandom), 1'($urandom), 1'($urandom), ($urandom % 4) == 0,
                1'($urandom), W'($urandom), 3'($urandom));
            if (($urandom % 50) == 0) begin
                @(negedge clk);
                fixed_span = 1'($urandom);
                strap_span = 3'($urandom);
            end
        end
        idle();
        idle();

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule